// File: doc/BRIEF.md
# Edge/level interrupt request latch

This block holds one pending-request bit for each of a set of interrupt lines, eight by default. Each line is set to edge or level behaviour by a trigger-mode register. In level mode the pending bit tracks the line. In edge mode the pending bit is set only by a low-to-high transition and stays set until that line is acknowledged. A per-instance constant mask limits which lines may be switched to level mode. The bits outside the mask stay in edge mode whatever is written.

A downstream interrupt controller uses the block as its front end. It reads the pending vector. When it services a line, it pulses the acknowledge strobe with that line's index. Edge detection compares each input with a registered copy of its value at the previous clock. The inputs must already be synchronous to `clk_i`. Every output is registered, so each change appears one clock after the input that causes it.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_ni` is low, and at the first clock after it rises with all inputs low, `pend_o` and `mode_o` are all zero. The stored previous level is also zero, so a line that is high at the first clock after reset counts as a rise.
- R2: For a line whose `mode_o` bit is 1 (level), `pend_o` after a rising clock edge equals the `req_i` value sampled at that edge, whether that value is high or low.
- R3: For a line whose `mode_o` bit is 0 (edge), `pend_o` becomes 1 after an edge at which `req_i` is 1 and was 0 at the previous edge.
- R4: For an edge-mode line, `req_i` falling does not clear `pend_o`. The bit stays set until that line is acknowledged.
- R5: When `ack_i` is 1 and `ack_idx_i` equals the index of an edge-mode line that has no new rise, that line's `pend_o` bit is 0 after the edge. Other lines are unaffected.
- R6: An acknowledge of a level-mode line has no effect: with `req_i` high, its `pend_o` bit stays 1.
- R7: When a rise and an acknowledge hit the same edge-mode line at the same edge, the rise wins and `pend_o` stays 1.
- R8: A write (`mode_we_i` = 1) loads `mode_o` with `mode_wdata_i & MODE_MASK` at the next edge. Bits outside the mask read 0. Without a write, `mode_o` holds its value, and the new mode governs `pend_o` from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_LINES | Synchronised request levels, one per line |
| mode_we_i | input | 1 | Trigger-mode write strobe |
| mode_wdata_i | input | NUM_LINES | Trigger-mode write data, 1 = level |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDX_W | Index of the acknowledged line |
| pend_o | output | NUM_LINES | Pending-request vector |
| mode_o | output | NUM_LINES | Trigger-mode readback |

## Verification
The bench builds two instances of eight lines, side by side, on shared stimulus. One uses mask 0xF8 and the other 0xDE. Because the masks differ, one write pattern gives each instance a different mix of edge and level lines. Bit 0 stays in edge mode in both instances, which makes it the fixed target for the case where a rise and an acknowledge land together. A behavioural model of both instances is compared every clock, over directed sequences and a long random run with occasional mode rewrites.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
  parameter int unsigned            NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0]   WR_MASK   = 'hF8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i & WR_MASK;
  end

  assign mode_o = mode_q;

  assert_write_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_q == $past(wdata_i & WR_MASK));
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_q));
endmodule

// File: rtl/line_latch.sv
module line_latch
  import irq_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  trig_e mode_i,
  input  logic  ack_hit_i,
  output logic  pend_o
);
  logic prev_q, pend_q, rise;

  assign rise = req_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      unique case (mode_i)
        TRIG_LEVEL: pend_q <= req_i;
        default: begin
          if (rise)           pend_q <= 1'b1;  // new request beats ack
          else if (ack_hit_i) pend_q <= 1'b0;
        end
      endcase
    end
  end

  assign pend_o = pend_q;

  assert_level_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL) |=> pend_q == $past(req_i));
  assert_edge_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && rise) |=> pend_q);
  assert_edge_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && pend_q && !ack_hit_i) |=> pend_q);
  assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_EDGE && ack_hit_i && !rise) |=> !pend_q);
  assert_level_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL && ack_hit_i && req_i) |=> pend_q);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] MODE_MASK = 'hF8,
  localparam int unsigned         IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 mode_we_i,
  input  logic [NUM_LINES-1:0] mode_wdata_i,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode_q;

  trig_mode_reg #(
    .NUM_LINES (NUM_LINES),
    .WR_MASK   (MODE_MASK)
  ) i_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit;
    assign hit = ack_i && (ack_idx_i == IDX_W'(i));
    line_latch i_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[i]),
      .mode_i    (trig_e'(mode_q[i])),
      .ack_hit_i (hit),
      .pend_o    (pend_o[i])
    );
  end

  assign mode_o = mode_q;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pend_o == '0 && mode_o == '0));
endmodule

// File: tb/test_irq_req_latch.sv
`timescale 1ns/1ps
module test_irq_req_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic       ack = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [7:0] pend_a, mode_a, pend_b, mode_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_req_latch #(.NUM_LINES(8), .MODE_MASK(8'hF8)) i_irq_req_latch (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_we_i(we), .mode_wdata_i(wdata),
    .ack_i(ack), .ack_idx_i(ack_idx), .pend_o(pend_a), .mode_o(mode_a));

  irq_req_latch #(.NUM_LINES(8), .MODE_MASK(8'hDE)) i_irq_req_latch_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_we_i(we), .mode_wdata_i(wdata),
    .ack_i(ack), .ack_idx_i(ack_idx), .pend_o(pend_b), .mode_o(mode_b));

  // behavioural reference: integers per instance
  int m_pend[2], m_prev[2], m_mode[2];
  int m_mask[2] = '{32'hF8, 32'hDE};

  initial for (int k = 0; k < 2; k++) begin m_pend[k] = 0; m_prev[k] = 0; m_mode[k] = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_pend[k] = 0; m_prev[k] = 0; m_mode[k] = 0; end
    end else begin
      for (int k = 0; k < 2; k++) begin
        int np;
        np = 0;
        for (int i = 0; i < 8; i++) begin
          int r, p, o;
          r = (int'(req) >> i) & 1;
          p = (m_prev[k] >> i) & 1;
          o = (m_pend[k] >> i) & 1;
          if ((m_mode[k] >> i) & 1) o = r;
          else if (r == 1 && p == 0) o = 1;
          else if (ack && int'(ack_idx) == i) o = 0;
          np = np | (o << i);
        end
        m_pend[k] = np;
        m_prev[k] = int'(req);
        if (we) m_mode[k] = int'(wdata) & m_mask[k];
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] pa[2], ma[2];
      pa[0] = pend_a; pa[1] = pend_b; ma[0] = mode_a; ma[1] = mode_b;
      for (int k = 0; k < 2; k++) begin
        logic [7:0] ep, diff;
        string tag;
        ep = m_pend[k][7:0];
        diff = pa[k] ^ ep;
        tag = "R3 edge pending";
        for (int i = 7; i >= 0; i--)
          if (diff[i]) tag = m_mode[k][i] ? "R2 level pending" : "R3 edge pending";
        check(tag, pa[k], ep);
        check("R8 mode readback", ma[k], m_mode[k][7:0]);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pend a", pend_a, 8'h00);
    check("R1 reset mode a", mode_a, 8'h00);
    check("R1 reset pend b", pend_b, 8'h00);
    check("R1 reset mode b", mode_b, 8'h00);
    #1 rst_n = 1'b1;
    tick();
    check("R1 after release", pend_a, 8'h00);
    // edge mode: rise, fall, ack
    req = 8'h08;
    tick();
    check("R3 rise sets", pend_a, 8'h08);
    req = 8'h00;
    tick();
    check("R4 fall keeps", pend_a, 8'h08);
    ack = 1'b1; ack_idx = 3'd3;
    tick();
    ack = 1'b0;
    check("R5 ack clears", pend_a, 8'h00);
    // mode write through masks
    we = 1'b1; wdata = 8'hFF;
    tick();
    we = 1'b0;
    check("R8 mask a", mode_a, 8'hF8);
    check("R8 mask b", mode_b, 8'hDE);
    req = 8'h90;
    tick();
    check("R2 level high a", pend_a, 8'h90);
    check("R2 level high b", pend_b, 8'h90);
    req = 8'h00;
    tick();
    check("R2 level low a", pend_a, 8'h00);
    req = 8'h80;
    tick();
    ack = 1'b1; ack_idx = 3'd7;
    tick();
    ack = 1'b0;
    check("R6 level ack ignored", pend_a, 8'h80);
    req = 8'h81; ack = 1'b1; ack_idx = 3'd0;
    tick();
    ack = 1'b0;
    check("R7 rise beats ack a", pend_a, 8'h81);
    check("R7 rise beats ack b", pend_b, 8'h81);
    we = 1'b1; wdata = 8'h07;
    tick();
    we = 1'b0;
    check("R8 masked bits a", mode_a, 8'h00);
    check("R8 masked bits b", mode_b, 8'h06);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      req = 8'($urandom);
      ack = 1'($urandom);
      ack_idx = 3'($urandom);
      we = (($urandom % 16) == 0);
      wdata = 8'($urandom);
      tick();
    end
    req = '0; ack = 1'b0; we = 1'b0;
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1-sequence actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule